// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform that an I2C master puts on SCL. It counts ticks of a free-running oscillator enable and drives a single "pull SCL low" request toward the pad. Between those requests it releases the line. It also tells the protocol engine where each bit begins and where it may sample. It offers two ways to set the bit rate. The first is a legacy style, where a 3-bit code selects one of eight fixed rates derived from the oscillator frequency. The second is a programmable style, where separate low and high counts set the waveform and a speed mode sets lower limits on both.

The high phase is timed from the moment the sampled SCL line is really high. A target that stretches the clock by holding SCL low therefore lengthens the high phase and does not shorten it. The protocol engine marks a transfer with a level input. Whenever that input is low, the generator returns to idle with SCL released. Count and mode changes are captured only when a low phase starts.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in every cycle that follows a clock edge at which `xfer_active` was low, `scl_drive_low`, `rise_stb` and `fall_stb` are all 0.
- R2: From idle, the first clock edge at which `xfer_active` is high starts a low phase. `scl_drive_low` and `fall_stb` are 1 in the following cycle.
- R3: With `cfg_prog`=1, a low phase lasts max(`low_cnt`, minimum low) oscillator ticks. The counted part of a high phase lasts max(`high_cnt`, minimum high) ticks. A count of 255 gives 255 ticks.
- R4: The minimums follow `speed_mode`: 0 is standard with low 157 and high 134, 1 is fast with 44 and 20, 2 is fast-plus with 17 and 9, and 3 is turbo with 14 and 5. A programmed count below its minimum is raised to that minimum.
- R5: With `cfg_prog`=0, `rate_code` c picks a rate in kHz: 330, 288, 217, 146, 88, 59, 44 or 36 for c = 0 to 7. With T = OSC_KHZ / rate (integer division), the low phase is T - T/2 ticks and the high phase is T/2 ticks. `speed_mode`, `low_cnt` and `high_cnt` are ignored in this style.
- R6: In the fixed style, a phase length above 255 saturates at 255. With OSC_KHZ = 19000, code 7 gives 255 for both phases.
- R7: High-phase ticks count only while `scl_in` is 1. If an external device holds SCL low for k clock edges after release, the released time grows by exactly k cycles.
- R8: Changes to the configuration inputs during a phase do not affect that phase or the high phase that follows it. They apply from the next low phase.
- R9: `fall_stb` pulses for one cycle at the start of each low phase. `rise_stb` pulses for exactly one cycle in each high phase, in the cycle after the first counted high tick.
- R10: Phases advance only on clock edges where `osc_tick` is 1. With a tick on every second cycle, each steady-state phase lasts twice its count in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| xfer_active | input | 1 | Protocol engine is in a transfer |
| cfg_prog | input | 1 | 1 selects programmable counts, 0 selects fixed rate table |
| rate_code | input | 3 | Fixed-rate selector, 0 is fastest |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 turbo |
| low_cnt | input | CNT_W | Programmed low-phase length in ticks |
| high_cnt | input | CNT_W | Programmed high-phase length in ticks |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| rise_stb | output | 1 | One-cycle strobe after SCL is first counted high |
| fall_stb | output | 1 | One-cycle strobe at the start of a low phase |

## Verification
A wrong latched count or a wrong clamp shows up as a phase of the wrong length at `scl_drive_low`, as soon as the first bit after a configuration ends. A counter that decrements during a stretch appears as a high phase that is short by the number of stretched cycles. A configuration captured at the wrong moment changes the length of the bit in progress, not the next one. The sweeps cover every mode with counts below, at and above each minimum, and every fixed rate code. Every measured phase is compared with its count in cycles.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      SPD_STD   = 2'd0,
      SPD_FAST  = 2'd1,
      SPD_FASTP = 2'd2,
      SPD_TURBO = 2'd3
   } speed_t;

   // shortest legal low phase per speed mode, in oscillator ticks
   function automatic int unsigned floor_low(input logic [1:0] m);
      case (m)
         2'd0:    return 157;
         2'd1:    return 44;
         2'd2:    return 17;
         default: return 14;
      endcase
   endfunction

   // shortest legal high phase per speed mode, in oscillator ticks
   function automatic int unsigned floor_high(input logic [1:0] m);
      case (m)
         2'd0:    return 134;
         2'd1:    return 20;
         2'd2:    return 9;
         default: return 5;
      endcase
   endfunction

   // legacy rate table in kHz, code 0 fastest
   function automatic int unsigned legacy_khz(input logic [2:0] c);
      case (c)
         3'd0:    return 330;
         3'd1:    return 288;
         3'd2:    return 217;
         3'd3:    return 146;
         3'd4:    return 88;
         3'd5:    return 59;
         3'd6:    return 44;
         default: return 36;
      endcase
   endfunction

endpackage

// File: rtl/scl_period_sel.sv
module scl_period_sel
   import scl_gen_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int OSC_KHZ   = 19000,
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic             cfg_prog,
   input  logic [2:0]       rate_code,
   input  logic [1:0]       speed_mode,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   output logic [CNT_W-1:0] eff_lo,
   output logic [CNT_W-1:0] eff_hi
);
   localparam int MAXC   = (1 << CNT_W) - 1;
   localparam int NRATES = 8;

   logic [CNT_W-1:0] p_lo, p_hi, m_lo, m_hi;

   // programmable style: raise each count to the mode floor
   always_comb begin
      m_lo = CNT_W'(floor_low(speed_mode));
      m_hi = CNT_W'(floor_high(speed_mode));
      p_lo = (low_cnt  < m_lo) ? m_lo : low_cnt;
      p_hi = (high_cnt < m_hi) ? m_hi : high_cnt;
   end

   if (HAS_FIXED) begin : g_fixed
      logic [CNT_W-1:0] fx_lo [NRATES];
      logic [CNT_W-1:0] fx_hi [NRATES];
      for (genvar g = 0; g < NRATES; g++) begin : g_code
         localparam int TOT  = OSC_KHZ / int'(legacy_khz(3'(g)));
         localparam int LO_R = TOT - TOT / 2;
         localparam int HI_R = TOT / 2;
         localparam int LO_S = (LO_R > MAXC) ? MAXC : ((LO_R < 2) ? 2 : LO_R);
         localparam int HI_S = (HI_R > MAXC) ? MAXC : ((HI_R < 2) ? 2 : HI_R);
         assign fx_lo[g] = CNT_W'(LO_S);
         assign fx_hi[g] = CNT_W'(HI_S);
      end
      assign eff_lo = cfg_prog ? p_lo : fx_lo[rate_code];
      assign eff_hi = cfg_prog ? p_hi : fx_hi[rate_code];
   end else begin : g_prog_only
      assign eff_lo = p_lo;
      assign eff_hi = p_hi;
   end
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
   import scl_gen_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             xfer_active,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] eff_lo,
   input  logic [CNT_W-1:0] eff_hi,
   output logic             scl_drive_low,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             ph_low,
   output logic             ph_high,
   output logic [CNT_W-1:0] hi_hold
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hi_q;
   logic             rise_q, fall_q;
   logic             hi_tick;

   assign hi_tick = osc_tick && scl_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         hi_q    <= '0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (!xfer_active) begin
            phase_q <= PH_IDLE;
         end else begin
            case (phase_q)
               PH_IDLE: begin
                  phase_q <= PH_LOW;
                  cnt_q   <= eff_lo;
                  hi_q    <= eff_hi;
                  fall_q  <= 1'b1;
               end
               PH_LOW: begin
                  if (osc_tick) begin
                     if (cnt_q <= ONE) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= hi_q;
                     end else begin
                        cnt_q <= cnt_q - ONE;
                     end
                  end
               end
               PH_HIGH: begin
                  if (hi_tick) begin
                     if (cnt_q == hi_q) rise_q <= 1'b1;
                     if (cnt_q <= ONE) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= eff_lo;
                        hi_q    <= eff_hi;
                        fall_q  <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q - ONE;
                     end
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign scl_drive_low = (phase_q == PH_LOW);
   assign ph_low        = (phase_q == PH_LOW);
   assign ph_high       = (phase_q == PH_HIGH);
   assign rise_stb      = rise_q;
   assign fall_stb      = fall_q;
   assign hi_hold       = hi_q;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_gen_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int OSC_KHZ   = 19000,
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             xfer_active,
   input  logic             cfg_prog,
   input  logic [2:0]       rate_code,
   input  logic [1:0]       speed_mode,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             rise_stb,
   output logic             fall_stb
);
   if (CNT_W < 8) begin : g_bad_width
      $error("CNT_W must hold the standard-mode floor of 157");
   end
   if (HAS_FIXED && (OSC_KHZ / 330 < 4)) begin : g_bad_osc
      $error("OSC_KHZ too low for the fastest legacy rate");
   end

   logic [CNT_W-1:0] eff_lo, eff_hi, hi_hold;
   logic             ph_low, ph_high;

   scl_period_sel #(
      .CNT_W(CNT_W), .OSC_KHZ(OSC_KHZ), .HAS_FIXED(HAS_FIXED)
   ) u_sel (
      .cfg_prog   (cfg_prog),
      .rate_code  (rate_code),
      .speed_mode (speed_mode),
      .low_cnt    (low_cnt),
      .high_cnt   (high_cnt),
      .eff_lo     (eff_lo),
      .eff_hi     (eff_hi)
   );

   scl_phase_ctl #(.CNT_W(CNT_W)) u_phase (
      .clk           (clk),
      .rst_n         (rst_n),
      .osc_tick      (osc_tick),
      .xfer_active   (xfer_active),
      .scl_in        (scl_in),
      .eff_lo        (eff_lo),
      .eff_hi        (eff_hi),
      .scl_drive_low (scl_drive_low),
      .rise_stb      (rise_stb),
      .fall_stb      (fall_stb),
      .ph_low        (ph_low),
      .ph_high       (ph_high),
      .hi_hold       (hi_hold)
   );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
   import scl_gen_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_tick,
   input logic             xfer_active,
   input logic             cfg_prog,
   input logic [1:0]       speed_mode,
   input logic [CNT_W-1:0] eff_lo,
   input logic [CNT_W-1:0] eff_hi,
   input logic [CNT_W-1:0] hi_hold,
   input logic             scl_in,
   input logic             scl_drive_low,
   input logic             rise_stb,
   input logic             fall_stb,
   input logic             ph_low,
   input logic             ph_high
);
   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |=> (!scl_drive_low && !rise_stb && !fall_stb));

   // R4
   floor_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_prog |-> (eff_lo >= CNT_W'(floor_low(speed_mode))));

   // R4
   floor_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_prog |-> (eff_hi >= CNT_W'(floor_high(speed_mode))));

   // R7
   stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_high && !scl_in && xfer_active) |=> !scl_drive_low);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_high && $past(ph_high)) |-> $stable(hi_hold));

   // R9
   fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

   // R9
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);

   // R10
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_low && !osc_tick && xfer_active) |=> ph_low);
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .osc_tick      (osc_tick),
   .xfer_active   (xfer_active),
   .cfg_prog      (cfg_prog),
   .speed_mode    (speed_mode),
   .eff_lo        (eff_lo),
   .eff_hi        (eff_hi),
   .hi_hold       (hi_hold),
   .scl_in        (scl_in),
   .scl_drive_low (scl_drive_low),
   .rise_stb      (rise_stb),
   .fall_stb      (fall_stb),
   .ph_low        (ph_low),
   .ph_high       (ph_high)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b1;
   logic       tick_alt = 1'b0;
   logic       xfer_active = 1'b0;
   logic       cfg_prog = 1'b1;
   logic [2:0] rate_code = 3'd0;
   logic [1:0] speed_mode = 2'd0;
   logic [7:0] low_cnt = 8'd0;
   logic [7:0] high_cnt = 8'd0;
   logic       stretch = 1'b0;
   logic       scl_in;
   logic       scl_drive_low, rise_stb, fall_stb;
   int         checks = 0;
   int         errors = 0;

   always #10 clk = ~clk;

   assign scl_in = !(scl_drive_low || stretch);

   always @(negedge clk) osc_tick <= tick_alt ? ~osc_tick : 1'b1;

   scl_timing_gen #(.CNT_W(8), .OSC_KHZ(19000), .HAS_FIXED(1'b1)) u_scl_timing_gen (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .xfer_active(xfer_active),
      .cfg_prog(cfg_prog), .rate_code(rate_code), .speed_mode(speed_mode),
      .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(scl_in),
      .scl_drive_low(scl_drive_low), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   function automatic int min_lo(input int m);
      case (m) 0: return 157; 1: return 44; 2: return 17; default: return 14; endcase
   endfunction
   function automatic int min_hi(input int m);
      case (m) 0: return 134; 1: return 20; 2: return 9; default: return 5; endcase
   endfunction
   function automatic int khz(input int c);
      case (c)
         0: return 330; 1: return 288; 2: return 217; 3: return 146;
         4: return 88;  5: return 59;  6: return 44;  default: return 36;
      endcase
   endfunction
   function automatic int sat(input int v);
      return (v > 255) ? 255 : ((v < 2) ? 2 : v);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic start(input logic prog, input int code, input int m,
                        input int lo, input int hi);
      @(negedge clk);
      xfer_active = 1'b0;
      cfg_prog = prog; rate_code = 3'(code); speed_mode = 2'(m);
      low_cnt = 8'(lo); high_cnt = 8'(hi);
      @(negedge clk);
      @(negedge clk);
      xfer_active = 1'b1;
   endtask

   // measures one bit starting at a negedge; stretches s edges after release
   task automatic run_bit(input int s, input int chg_at, input int nlo, input int nhi,
                          output int lo, output int hi, output int rs, output int fs);
      lo = 0; hi = 0; rs = 0; fs = 0;
      while (!scl_drive_low) @(negedge clk);
      while (scl_drive_low) begin
         lo++;
         if (fall_stb) fs++;
         if (lo == chg_at) begin low_cnt = 8'(nlo); high_cnt = 8'(nhi); end
         @(negedge clk);
      end
      stretch = (s > 0);
      while (!scl_drive_low) begin
         hi++;
         if (rise_stb) rs++;
         if (hi == s + 1) stretch = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int lo, hi, rs, fs, el, eh;
      // R1: reset state and idle with transfer off
      #5;
      check("R1 drive in reset", int'(scl_drive_low), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 drive idle", int'(scl_drive_low), 0);
      check("R1 strobes idle", int'(rise_stb) + int'(fall_stb), 0);

      // R2: low phase starts one cycle after active is seen
      start(1'b1, 0, 1, 50, 30);
      @(negedge clk);
      check("R2 drive low", int'(scl_drive_low), 1);
      check("R2 fall strobe", int'(fall_stb), 1);
      repeat (5) @(negedge clk);
      xfer_active = 1'b0;
      @(negedge clk);
      check("R1 release after drop", int'(scl_drive_low), 0);
      @(negedge clk);
      check("R1 stays released", int'(scl_drive_low), 0);

      // R3 R4 R9: programmable sweep across modes and counts
      for (int m = 0; m < 4; m++) begin
         for (int li = 0; li < 3; li++) begin
            for (int hj = 0; hj < 3; hj++) begin
               int pl, ph;
               pl = (li == 0) ? 0 : min_lo(m) + ((li == 2) ? 3 : 0);
               ph = (hj == 0) ? 0 : min_hi(m) + ((hj == 2) ? 3 : 0);
               el = (pl < min_lo(m)) ? min_lo(m) : pl;
               eh = (ph < min_hi(m)) ? min_hi(m) : ph;
               start(1'b1, 0, m, pl, ph);
               for (int b = 0; b < 2; b++) begin
                  run_bit(0, 0, 0, 0, lo, hi, rs, fs);
                  check("R3 R4 low length", lo, el);
                  check("R3 R4 high length", hi, eh);
                  check("R9 rise pulses", rs, 1);
                  check("R9 fall pulses", fs, 1);
               end
            end
         end
      end

      // R3: full-scale counts
      start(1'b1, 0, 0, 255, 255);
      run_bit(0, 0, 0, 0, lo, hi, rs, fs);
      check("R3 low 255", lo, 255);
      check("R3 high 255", hi, 255);

      // R5 R6: fixed-rate sweep, programmable fields set to values that would differ
      for (int c = 0; c < 8; c++) begin
         int t;
         t  = 19000 / khz(c);
         el = sat(t - t / 2);
         eh = sat(t / 2);
         start(1'b0, c, 3, 3, 3);
         for (int b = 0; b < 2; b++) begin
            run_bit(0, 0, 0, 0, lo, hi, rs, fs);
            check(c == 7 ? "R6 fixed low saturated" : "R5 fixed low", lo, el);
            check(c == 7 ? "R6 fixed high saturated" : "R5 fixed high", hi, eh);
         end
      end

      // R7: clock stretching lengthens the released time
      start(1'b1, 0, 1, 50, 30);
      run_bit(7, 0, 0, 0, lo, hi, rs, fs);
      check("R7 low unchanged", lo, 50);
      check("R7 stretched high 7", hi, 37);
      check("R7 one rise pulse", rs, 1);
      run_bit(1, 0, 0, 0, lo, hi, rs, fs);
      check("R7 stretched high 1", hi, 31);

      // R8: mid-phase configuration change applies at next low phase
      start(1'b1, 0, 1, 60, 40);
      run_bit(0, 10, 70, 25, lo, hi, rs, fs);
      check("R8 current low kept", lo, 60);
      check("R8 current high kept", hi, 40);
      run_bit(0, 0, 0, 0, lo, hi, rs, fs);
      check("R8 next low new", lo, 70);
      check("R8 next high new", hi, 25);

      // R10: tick on every second cycle
      tick_alt = 1'b1;
      start(1'b1, 0, 2, 20, 12);
      run_bit(0, 0, 0, 0, lo, hi, rs, fs);
      check_rng("R10 first low", lo, 39, 40);
      check("R10 first high", hi, 24);
      run_bit(0, 0, 0, 0, lo, hi, rs, fs);
      check("R10 steady low", lo, 40);
      check("R10 steady high", hi, 24);
      tick_alt = 1'b0;

      @(negedge clk);
      xfer_active = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 final idle", int'(scl_drive_low), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule